// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is the serial core of an SPI master. Once started, it runs one frame of a programmed number of words. It pulls each transmit word from a valid/ready source. It shifts the word out on `mosi` while it shifts a word in from `miso`. Each completed receive word appears on a one-cycle valid output. The serial clock comes from a programmable divider. The word size, the bit order, the clock rest level and the edge on which data is driven are configurable. Chip select is either generated by the frame itself or forced by software.

Configuration is latched when a frame starts and is held for the whole frame. Three one-cycle pulses report events: the end of a frame, a transmit word that was due but missing (it is replaced by zeros), and a received word that the sink did not take (it is dropped). The FIFOs, the register decode and any DMA sit outside this block.

Top module: `spi_frame_engine`

## Requirements
- R1: Each half period of `sclk` lasts `cfg_div`+1 core clocks, so a full period is 2·(`cfg_div`+1) clocks. Outside a frame, `sclk` rests at `cfg_clk_idle`, and it returns to that level after the last edge of a frame.
- R2: The 2-bit `cfg_fmt` sets the word size: 0 → 8 bits, 1 → 12, 2 → 16, 3 → 32. Transmit words are taken from the low bits of `tx_data`. Receive words are returned right-justified on `rx_data`, with zeros above the word.
- R3: With `cfg_msb_first`=1, each word is shifted most significant bit first. With 0, it is shifted least significant bit first. The same order applies to `mosi` and to the assembly of the `miso` bits.
- R4: With `cfg_drive_rise`=1, `mosi` changes only on rising `sclk` edges and `miso` is sampled on falling edges. With 0, the two edges are swapped. `mosi` is stable across every sampling edge.
- R5: With `cfg_cs_sw_en`=0, `cs_o` equals the inverse of `cfg_cs_idle_level` while `busy` is high and equals `cfg_cs_idle_level` otherwise.
- R6: With `cfg_cs_sw_en`=1, `cs_o` equals `cfg_cs_sw_level` at all times, including between frames.
- R7: A frame moves exactly `cfg_len_m1`+1 words. `frame_done` then pulses for one cycle, in the cycle where `busy` first reads low.
- R8: If a word is due while `tx_valid` is low, `tx_underflow` pulses for one cycle and that word is sent as all zeros.
- R9: If a received word is presented with `rx_valid` while `rx_ready` is low, `rx_overflow` pulses in the following cycle and the word is lost.
- R10: A `start` pulse while `busy` is high is ignored. The running frame keeps its length and configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | DIV_W | Half-period divider value |
| cfg_fmt | input | 2 | Word size code |
| cfg_msb_first | input | 1 | 1 = most significant bit first |
| cfg_clk_idle | input | 1 | Rest level of `sclk` |
| cfg_drive_rise | input | 1 | 1 = drive `mosi` on rising edges |
| cfg_cs_sw_en | input | 1 | Chip select under software control |
| cfg_cs_sw_level | input | 1 | Software chip select level |
| cfg_cs_idle_level | input | 1 | Inactive chip select level |
| cfg_len_m1 | input | CNT_W | Words per frame minus one |
| start | input | 1 | Start a frame (single-cycle pulse) |
| tx_data | input | DATA_W | Transmit word, right-justified |
| tx_valid | input | 1 | Transmit word available |
| tx_ready | output | 1 | Transmit word taken this cycle |
| rx_data | output | DATA_W | Received word, right-justified |
| rx_valid | output | 1 | Received word valid (one cycle) |
| rx_ready | input | 1 | Sink can take a word |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_o | output | 1 | Chip select |
| busy | output | 1 | Frame in progress |
| frame_done | output | 1 | Frame end pulse |
| tx_underflow | output | 1 | Missing transmit word pulse |
| rx_overflow | output | 1 | Dropped receive word pulse |

## Verification
The hardest states to reach are the word boundaries where the data source or sink stalls. These are a transmit word due while the source is empty, and a finished receive word while the sink refuses it. The bench gives the source fewer words than the frame length, so the later words of the same frame underflow and must go out as zeros. A separate frame holds `rx_ready` low throughout so that every word overflows. A second `start` injected in the middle of a frame checks that the running frame is left undisturbed. A bench monitor on the serial lines rebuilds each bit stream independently, for every clock mode and word size.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    typedef enum logic [1:0] {
        FMT_W8  = 2'd0,
        FMT_W12 = 2'd1,
        FMT_W16 = 2'd2,
        FMT_W32 = 2'd3
    } word_fmt_e;

    localparam int BITCNT_W = 6;

    // Bits per word for each format code
    function automatic logic [BITCNT_W-1:0] fmt_bits(input word_fmt_e f);
        case (f)
            FMT_W8:  fmt_bits = 6'd8;
            FMT_W12: fmt_bits = 6'd12;
            FMT_W16: fmt_bits = 6'd16;
            default: fmt_bits = 6'd32;
        endcase
    endfunction

endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        tick  = 1'b0;
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q == div) begin
            tick  = 1'b1;
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R1: the half-period counter never passes the programmed limit
    p_half_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> cnt_q <= div);

endmodule

// File: rtl/spi_cs_sel.sv
module spi_cs_sel (
    input  logic frame_active,
    input  logic sw_en,
    input  logic sw_level,
    input  logic idle_level,
    output logic cs_out
);
    always_comb begin
        if (sw_en)             cs_out = sw_level;
        else if (frame_active) cs_out = ~idle_level;
        else                   cs_out = idle_level;
    end
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine #(
    parameter int DATA_W = 32,   // must be at least 32 to hold the widest format
    parameter int CNT_W  = 16,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [1:0]        cfg_fmt,
    input  logic              cfg_msb_first,
    input  logic              cfg_clk_idle,
    input  logic              cfg_drive_rise,
    input  logic              cfg_cs_sw_en,
    input  logic              cfg_cs_sw_level,
    input  logic              cfg_cs_idle_level,
    input  logic [CNT_W-1:0]  cfg_len_m1,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_o,
    output logic              busy,
    output logic              frame_done,
    output logic              tx_underflow,
    output logic              rx_overflow
);
    import spi_eng_pkg::*;

    localparam logic [BITCNT_W-1:0] DATA_BITS = BITCNT_W'(DATA_W);

    typedef struct packed {
        logic                busy;
        logic                phase;     // 0: before first edge of bit, 1: after
        logic [BITCNT_W-1:0] bit_cnt;
        logic [CNT_W-1:0]    word_cnt;
        logic [CNT_W-1:0]    len;
        logic [DIV_W-1:0]    div;
        word_fmt_e           fmt;
        logic                msb;
        logic                cpol;
        logic                drv;
        logic [DATA_W-1:0]   tx_sr;
        logic [DATA_W-1:0]   rx_sr;
        logic [DATA_W-1:0]   rx_data;
        logic                mosi;
        logic                sclk;
        logic                rx_valid;
        logic                done;
        logic                unf;
        logic                ovf;
    } eng_t;

    eng_t d, q;

    logic                tick;
    logic                load;
    logic                cpha;
    logic [BITCNT_W-1:0] nbits, shamt, ld_shamt;
    logic [DATA_W-1:0]   rx_in, rx_now, word, aligned;

    function automatic logic lead_bit(input logic [DATA_W-1:0] s, input logic m);
        lead_bit = m ? s[DATA_W-1] : s[0];
    endfunction

    function automatic logic [DATA_W-1:0] advance(input logic [DATA_W-1:0] s, input logic m);
        advance = m ? (s << 1) : (s >> 1);
    endfunction

    spi_half_tick #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (q.busy),
        .div   (q.div),
        .tick  (tick)
    );

    spi_cs_sel u_cs (
        .frame_active (q.busy),
        .sw_en        (cfg_cs_sw_en),
        .sw_level     (cfg_cs_sw_level),
        .idle_level   (cfg_cs_idle_level),
        .cs_out       (cs_o)
    );

    always_comb begin
        d          = q;
        load       = 1'b0;
        d.rx_valid = 1'b0;
        d.done     = 1'b0;
        d.unf      = 1'b0;
        d.ovf      = q.rx_valid & ~rx_ready;
        nbits      = fmt_bits(q.fmt);
        shamt      = DATA_BITS - nbits;
        cpha       = q.cpol ^ q.drv;
        rx_in      = q.msb ? {q.rx_sr[DATA_W-2:0], miso} : {miso, q.rx_sr[DATA_W-1:1]};
        rx_now     = q.rx_sr;
        word       = '0;
        aligned    = '0;
        ld_shamt   = '0;

        if (!q.busy) begin
            if (start) begin
                d.busy     = 1'b1;
                d.phase    = 1'b0;
                d.bit_cnt  = '0;
                d.word_cnt = '0;
                d.len      = cfg_len_m1;
                d.div      = cfg_div;
                d.fmt      = word_fmt_e'(cfg_fmt);
                d.msb      = cfg_msb_first;
                d.cpol     = cfg_clk_idle;
                d.drv      = cfg_drive_rise;
                d.rx_sr    = '0;
                d.sclk     = cfg_clk_idle;
                load       = 1'b1;
            end
        end else if (tick) begin
            if (!q.phase) begin
                // leading edge of the bit
                d.phase = 1'b1;
                d.sclk  = ~q.cpol;
                if (!cpha) begin
                    d.rx_sr = rx_in;
                end else begin
                    d.mosi  = lead_bit(q.tx_sr, q.msb);
                    d.tx_sr = advance(q.tx_sr, q.msb);
                end
            end else begin
                // trailing edge of the bit
                d.phase = 1'b0;
                d.sclk  = q.cpol;
                rx_now  = cpha ? rx_in : q.rx_sr;
                d.rx_sr = rx_now;
                if (q.bit_cnt != nbits - 1'b1) begin
                    d.bit_cnt = q.bit_cnt + 1'b1;
                    if (!cpha) begin
                        d.mosi  = lead_bit(q.tx_sr, q.msb);
                        d.tx_sr = advance(q.tx_sr, q.msb);
                    end
                end else begin
                    d.bit_cnt  = '0;
                    d.rx_valid = 1'b1;
                    d.rx_data  = q.msb ? (rx_now & ({DATA_W{1'b1}} >> shamt))
                                       : (rx_now >> shamt);
                    if (q.word_cnt == q.len) begin
                        d.busy = 1'b0;
                        d.done = 1'b1;
                    end else begin
                        d.word_cnt = q.word_cnt + 1'b1;
                        load       = 1'b1;
                    end
                end
            end
        end

        if (load) begin
            ld_shamt = DATA_BITS - fmt_bits(d.fmt);
            word     = tx_valid ? tx_data : '0;
            d.unf    = ~tx_valid;
            aligned  = d.msb ? (word << ld_shamt) : word;
            if (!(d.cpol ^ d.drv)) begin
                d.mosi  = lead_bit(aligned, d.msb);
                d.tx_sr = advance(aligned, d.msb);
            end else begin
                d.tx_sr = aligned;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tx_ready     = load;
    assign rx_data      = q.rx_data;
    assign rx_valid     = q.rx_valid;
    assign sclk         = q.busy ? q.sclk : cfg_clk_idle;
    assign mosi         = q.mosi;
    assign busy         = q.busy;
    assign frame_done   = q.done;
    assign tx_underflow = q.unf;
    assign rx_overflow  = q.ovf;

    // R1: the serial clock is back at its rest level when a frame ends
    p_rest_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.busy) |-> q.sclk == q.cpol);

    // R2: the bit counter stays inside the selected word size
    p_bitcnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> q.bit_cnt < fmt_bits(q.fmt));

    // R4: mosi holds across every sampling edge
    p_mosi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && $past(q.busy) && q.sclk != $past(q.sclk) && q.sclk != q.drv)
        |-> $stable(q.mosi));

    // R7: the end pulse appears only as the frame closes
    p_done_close_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !busy && $past(busy));

    // R8: an underflow is only reported inside a frame
    p_unf_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_underflow |-> busy);

    // R9: an overflow pulse never coincides with a new received word
    p_ovf_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overflow |-> !rx_valid);

endmodule

// File: tb/spi_frame_engine_test.sv
module spi_frame_engine_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_div = '0;
    logic [1:0]  cfg_fmt = '0;
    logic        cfg_msb_first = 1'b1;
    logic        cfg_clk_idle = 1'b0;
    logic        cfg_drive_rise = 1'b0;
    logic        cfg_cs_sw_en = 1'b0;
    logic        cfg_cs_sw_level = 1'b0;
    logic        cfg_cs_idle_level = 1'b1;
    logic [15:0] cfg_len_m1 = '0;
    logic        start = 1'b0;
    logic [31:0] tx_data;
    logic        tx_valid;
    logic        tx_ready;
    logic [31:0] rx_data;
    logic        rx_valid;
    logic        rx_ready = 1'b1;
    logic        sclk, mosi, miso, cs_o, busy, frame_done, tx_underflow, rx_overflow;

    logic        miso_one = 1'b0;
    logic        mon = 1'b0;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    logic [31:0] tx_mem [0:7];
    int tx_idx = 0, tx_base = 0, tx_cnt = 0;

    bit          cap [0:2047];
    logic [31:0] rx_got [0:63];
    int          rise_t [0:63];
    int cap_n = 0, rx_n = 0, rise_n = 0, done_n = 0, unf_n = 0, ovf_n = 0, cs_bad = 0, hold_bad = 0;
    int cap_b, rx_b, rise_b, done_b, unf_b, ovf_b, cs_b, hold_b;
    logic sclk_prev = 1'b0;
    logic mosi_prev = 1'b0;

    always #5 clk = ~clk;

    assign miso     = miso_one ? 1'b1 : mosi;
    assign tx_valid = (tx_idx - tx_base) < tx_cnt;
    assign tx_data  = tx_mem[(tx_idx - tx_base) & 7];

    spi_frame_engine uut (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_fmt(cfg_fmt),
        .cfg_msb_first(cfg_msb_first), .cfg_clk_idle(cfg_clk_idle),
        .cfg_drive_rise(cfg_drive_rise), .cfg_cs_sw_en(cfg_cs_sw_en),
        .cfg_cs_sw_level(cfg_cs_sw_level), .cfg_cs_idle_level(cfg_cs_idle_level),
        .cfg_len_m1(cfg_len_m1), .start(start), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .sclk(sclk), .mosi(mosi),
        .miso(miso), .cs_o(cs_o), .busy(busy), .frame_done(frame_done),
        .tx_underflow(tx_underflow), .rx_overflow(rx_overflow)
    );

    always @(posedge clk) begin
        if (tx_valid && tx_ready) tx_idx <= tx_idx + 1;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests + 1, fails + 1);
            $finish;
        end
    end

    // Serial monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (mon) begin
            if (sclk != sclk_prev && sclk == ~cfg_drive_rise) begin
                cap[cap_n & 2047] = mosi;
                cap_n++;
                if (mosi !== mosi_prev) hold_bad++;
            end
            if (sclk && !sclk_prev) begin
                rise_t[rise_n & 63] = cyc;
                rise_n++;
            end
        end
        if (frame_done)   done_n++;
        if (tx_underflow) unf_n++;
        if (rx_overflow)  ovf_n++;
        if (rx_valid && rx_ready) begin
            rx_got[rx_n & 63] = rx_data;
            rx_n++;
        end
        if (cfg_cs_sw_en) begin
            if (cs_o !== cfg_cs_sw_level) cs_bad++;
        end else if (busy) begin
            if (cs_o !== ~cfg_cs_idle_level) cs_bad++;
        end else begin
            if (cs_o !== cfg_cs_idle_level) cs_bad++;
        end
        sclk_prev = sclk;
        mosi_prev = mosi;
    end

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int nbits_of(input logic [1:0] f);
        case (f)
            2'd0: return 8;
            2'd1: return 12;
            2'd2: return 16;
            default: return 32;
        endcase
    endfunction

    task automatic run_frame(input logic [1:0] fmt, input logic msb, input logic cpol,
                             input logic drv, input logic [15:0] div, input int nw,
                             input int ntx, input bit extra);
        cfg_fmt = fmt; cfg_msb_first = msb; cfg_clk_idle = cpol;
        cfg_drive_rise = drv; cfg_div = div; cfg_len_m1 = 16'(nw - 1);
        @(negedge clk);
        tx_base = tx_idx; tx_cnt = ntx;
        cap_b = cap_n; rx_b = rx_n; rise_b = rise_n; done_b = done_n;
        unf_b = unf_n; ovf_b = ovf_n; cs_b = cs_bad; hold_b = hold_bad;
        mon = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (extra) begin
            repeat (6) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        mon = 1'b0;
    endtask

    task automatic expect_serial(input string req, input logic [1:0] fmt, input logic msb,
                                 input int nw, input int ntx);
        int n = nbits_of(fmt);
        int k = 0;
        int mism = 0;
        for (int w = 0; w < nw; w++) begin
            logic [31:0] word = (w < ntx) ? tx_mem[w] : 32'h0;
            for (int b = 0; b < n; b++) begin
                int idx = msb ? (n - 1 - b) : b;
                if (cap[(cap_b + k) & 2047] != word[idx]) mism++;
                k++;
            end
        end
        check(req, "serial bit count", 32'(cap_n - cap_b), 32'(nw * n));
        check(req, "serial bit mismatches", 32'(mism), 32'h0);
    endtask

    task automatic expect_rx(input string req, input logic [1:0] fmt, input int nw,
                             input int ntx, input bit ones);
        int n = nbits_of(fmt);
        logic [31:0] mask = 32'((64'd1 << n) - 64'd1);
        check(req, "rx word count", 32'(rx_n - rx_b), 32'(nw));
        for (int w = 0; w < nw; w++) begin
            logic [31:0] e = ones ? mask : ((w < ntx) ? (tx_mem[w] & mask) : 32'h0);
            check(req, "rx word", rx_got[(rx_b + w) & 63], e);
        end
    endtask

    task automatic expect_period(input string req, input logic [15:0] div);
        check(req, "sclk period", 32'(rise_t[(rise_b + 1) & 63] - rise_t[rise_b & 63]),
              32'(2 * (int'(div) + 1)));
    endtask

    task automatic t_reset;
        check("R1", "sclk at rest after reset", {31'h0, sclk}, 32'h0);
        check("R5", "cs idle after reset", {31'h0, cs_o}, 32'h1);
        check("R7", "busy after reset", {31'h0, busy}, 32'h0);
        check("R7", "done after reset", {31'h0, frame_done}, 32'h0);
        check("R2", "rx_valid after reset", {31'h0, rx_valid}, 32'h0);
        check("R8", "tx_ready after reset", {31'h0, tx_ready}, 32'h0);
    endtask

    task automatic t_mode0_byte;
        tx_mem[0] = 32'hA5; tx_mem[1] = 32'h3C; tx_mem[2] = 32'hFFFF_FF81;
        run_frame(2'd0, 1'b1, 1'b0, 1'b0, 16'd1, 3, 3, 1'b0);
        expect_serial("R3", 2'd0, 1'b1, 3, 3);
        expect_rx("R2", 2'd0, 3, 3, 1'b0);
        expect_period("R1", 16'd1);
        check("R7", "frame_done pulses", 32'(done_n - done_b), 32'h1);
        check("R7", "words consumed", 32'(tx_idx - tx_base), 32'h3);
        check("R5", "cs errors", 32'(cs_bad - cs_b), 32'h0);
        check("R4", "mosi moved at sample edge", 32'(hold_bad - hold_b), 32'h0);
    endtask

    task automatic t_mode3_12lsb;
        tx_mem[0] = 32'h0000_0B3D; tx_mem[1] = 32'h0000_F4C2;
        run_frame(2'd1, 1'b0, 1'b1, 1'b0, 16'd2, 2, 2, 1'b0);
        expect_serial("R3", 2'd1, 1'b0, 2, 2);
        expect_rx("R2", 2'd1, 2, 2, 1'b0);
        expect_period("R1", 16'd2);
        check("R4", "mosi moved at sample edge", 32'(hold_bad - hold_b), 32'h0);
        check("R1", "sclk rest high after frame", {31'h0, sclk}, 32'h1);
    endtask

    task automatic t_mode1_16;
        tx_mem[0] = 32'h0000_8001; tx_mem[1] = 32'h1234_5A6B;
        run_frame(2'd2, 1'b1, 1'b0, 1'b1, 16'd0, 2, 2, 1'b0);
        expect_serial("R3", 2'd2, 1'b1, 2, 2);
        expect_rx("R2", 2'd2, 2, 2, 1'b0);
        expect_period("R1", 16'd0);
        check("R4", "mosi moved at sample edge", 32'(hold_bad - hold_b), 32'h0);
    endtask

    task automatic t_mode2_32lsb;
        tx_mem[0] = 32'hDEAD_BEEF; tx_mem[1] = 32'h8000_0001;
        run_frame(2'd3, 1'b0, 1'b1, 1'b1, 16'd3, 2, 2, 1'b0);
        expect_serial("R3", 2'd3, 1'b0, 2, 2);
        expect_rx("R2", 2'd3, 2, 2, 1'b0);
        expect_period("R1", 16'd3);
        check("R4", "mosi moved at sample edge", 32'(hold_bad - hold_b), 32'h0);
    endtask

    task automatic t_underflow;
        tx_mem[0] = 32'hC3;
        run_frame(2'd0, 1'b1, 1'b0, 1'b0, 16'd0, 3, 1, 1'b0);
        check("R8", "underflow pulses", 32'(unf_n - unf_b), 32'h2);
        expect_serial("R8", 2'd0, 1'b1, 3, 1);
        expect_rx("R8", 2'd0, 3, 1, 1'b0);
        check("R7", "frame_done pulses", 32'(done_n - done_b), 32'h1);
    endtask

    task automatic t_overflow;
        tx_mem[0] = 32'h55; tx_mem[1] = 32'hAA;
        rx_ready = 1'b0;
        run_frame(2'd0, 1'b1, 1'b0, 1'b0, 16'd0, 2, 2, 1'b0);
        rx_ready = 1'b1;
        check("R9", "overflow pulses", 32'(ovf_n - ovf_b), 32'h2);
        check("R9", "words accepted by sink", 32'(rx_n - rx_b), 32'h0);
    endtask

    task automatic t_sw_cs;
        cfg_cs_sw_en = 1'b1; cfg_cs_sw_level = 1'b0; cfg_cs_idle_level = 1'b1;
        @(negedge clk);
        check("R6", "software cs before frame", {31'h0, cs_o}, 32'h0);
        tx_mem[0] = 32'h0F;
        run_frame(2'd0, 1'b1, 1'b0, 1'b0, 16'd1, 1, 1, 1'b0);
        check("R6", "cs errors under software control", 32'(cs_bad - cs_b), 32'h0);
        cfg_cs_sw_level = 1'b1;
        @(negedge clk);
        check("R6", "software cs follows level", {31'h0, cs_o}, 32'h1);
        cfg_cs_sw_en = 1'b0;
        @(negedge clk);
        check("R5", "hardware cs back to idle", {31'h0, cs_o}, 32'h1);
    endtask

    task automatic t_busy_start;
        tx_mem[0] = 32'h96; tx_mem[1] = 32'h69; tx_mem[2] = 32'h11;
        run_frame(2'd0, 1'b1, 1'b0, 1'b0, 16'd1, 2, 3, 1'b1);
        check("R10", "frame_done pulses", 32'(done_n - done_b), 32'h1);
        check("R10", "words consumed", 32'(tx_idx - tx_base), 32'h2);
        check("R10", "busy after frame", {31'h0, busy}, 32'h0);
        expect_rx("R10", 2'd0, 2, 2, 1'b0);
    endtask

    task automatic t_miso_high;
        tx_mem[0] = 32'h0000_0123;
        miso_one = 1'b1;
        run_frame(2'd1, 1'b1, 1'b0, 1'b0, 16'd0, 1, 1, 1'b0);
        miso_one = 1'b0;
        expect_rx("R2", 2'd1, 1, 1, 1'b1);
        check("R7", "single-word frame done", 32'(done_n - done_b), 32'h1);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) tx_mem[i] = 32'h0;
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_mode0_byte();
        t_mode3_12lsb();
        t_mode1_16();
        t_mode2_32lsb();
        t_underflow();
        t_overflow();
        t_sw_cs();
        t_busy_start();
        t_miso_high();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule